// File: doc/BRIEF.md
# ATA Host Controller Register Bank

This block is the software-visible register bank of a parallel ATA host controller. A processor reaches it through a simple 32-bit request port. One address bit separates the host's own registers from the register window of the attached drives. Host registers hold the control word, a read-only status word, a compatible-mode PIO timing word, per-drive fast PIO timing words, two DMA timing words, and a transmit and receive data buffer. Drive accesses are passed through to a device port only while the controller is enabled.

A build-time feature level decides which registers are present. A register that is absent reads as zero. The timing registers reset to values packed from per-mode default timing parameters. A sticky interrupt flag is raised by the controller core and cleared only by software. The control word's reset bit drives the hardware reset line of the drives.

Top module: `ata_host_regs`

## Requirements
- R1: After reset the control word is 0x00000001, `dev_rst_o` is 1 and `irq_o` is 0. The PIO timing words reset to 0x17021C06, which packs end-of-cycle 23 in [31:24], T4 2 in [23:16], T2 28 in [15:8] and T1 6 in [7:0]. The DMA timing words reset to 0x15001504, which packs end-of-cycle 21 in [31:24], Td 21 in [15:8] and Tm 4 in [7:0].
- R2: The status word reads as the effective feature level in [31:28], the low 4 bits of the configured revision in [27:24], zeros in [23:1] and the interrupt flag in bit 0.
- R3: A configured feature level outside 1..3 behaves as level 1.
- R4: Both fast PIO timing words (offsets 0x0C and 0x10) read as zero unless the level is at least 2.
- R5: Both DMA timing words (0x14, 0x18) and the receive buffer (read at 0x1C) read as zero unless the level is 3. A write to 0x1C loads the transmit buffer, which appears on `tx_data_o`. A pulse on `rx_load_i` loads the receive buffer.
- R6: A host address whose bits [ADDR_W-2:5] are non-zero reads as zero, and a write to it changes no register.
- R7: A cycle with `irq_raise_i` high sets the interrupt flag at the next edge. A raise while the flag is already set leaves it set. A raise wins over a clear in the same cycle.
- R8: A status write clears the interrupt flag only when bit 0 of the written data is 0. No other status bit can be written.
- R9: A control write stores all 32 bits. From the following cycle, `dev_rst_o` equals bit 0 of the written value.
- R10: A host access, or a drive access made while disabled, asserts `ack_o` exactly 2 cycles after the request cycle, with read data on `rdata_o` in that cycle. A write takes effect at the edge that ends the request cycle.
- R11: While control bit 7 is set, a request with address bit ADDR_W-1 at 0 is forwarded in the same cycle on `dev_req_o`, with address bits [6:0], the write flag and the write data. `dev_ack_i` and `dev_rdata_i` are returned on `ack_o` and `rdata_o` in the cycle they arrive.
- R12: While control bit 7 is clear, a drive request is not forwarded. It completes per R10 with read data zero.
- R13: Host registers are selected by address bit ADDR_W-1 = 1 at these word offsets: 0x00 control, 0x04 status, 0x08 compatible PIO timing, 0x0C/0x10 fast PIO timing for drive 0/1, 0x14/0x18 DMA timing, 0x1C data buffer. The control word and the timing words read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Single-cycle access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; MSB selects host registers |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access complete |
| rdata_o | output | 32 | Read data, valid with ack_o |
| irq_raise_i | input | 1 | Interrupt event from the controller core |
| irq_o | output | 1 | Sticky interrupt request |
| dev_rst_o | output | 1 | Hardware reset to the drives |
| dev_req_o | output | 1 | Forwarded drive access |
| dev_we_o | output | 1 | Forwarded write flag |
| dev_addr_o | output | 7 | Forwarded drive register address |
| dev_wdata_o | output | 32 | Forwarded write data |
| dev_ack_i | input | 1 | Drive access complete |
| dev_rdata_i | input | 32 | Drive read data |
| rx_load_i | input | 1 | Load receive buffer |
| rx_data_i | input | 32 | Receive buffer data |
| tx_data_o | output | 32 | Transmit buffer contents |

## Verification
Host reads and disabled drive accesses are due exactly two edges after the request cycle. The bench samples on falling edges and checks that `ack_o` is low one cycle after the request and high with the data the cycle after that. Forwarded drive accesses answer combinationally, so those outputs are sampled in the request cycle itself. The interrupt flag, `dev_rst_o` and register contents change on the first edge after the request. They are checked at the next falling edge or through a later read. Three instances with different feature levels and revisions receive the same stimulus. Every offset of each is swept against a model computed in the bench.

// File: rtl/ahr_pkg.sv
package ahr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned DEV_AW = 7;
  localparam int unsigned N_TIM = 5;
  localparam int unsigned CTRL_RST_BIT = 0;
  localparam int unsigned CTRL_EN_BIT = 7;
  localparam int unsigned STAT_IRQ_BIT = 0;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_PIO   = 3'd2,
    SEL_FAST0 = 3'd3,
    SEL_FAST1 = 3'd4,
    SEL_DMA0  = 3'd5,
    SEL_DMA1  = 3'd6,
    SEL_BUF   = 3'd7
  } reg_sel_e;

  function automatic logic [DW-1:0] pack_pio(int unsigned t1, int unsigned t2,
                                             int unsigned t4, int unsigned teoc);
    return {teoc[7:0], t4[7:0], t2[7:0], t1[7:0]};
  endfunction

  function automatic logic [DW-1:0] pack_dma(int unsigned tm, int unsigned td,
                                             int unsigned teoc);
    return {teoc[7:0], 8'h00, td[7:0], tm[7:0]};
  endfunction
endpackage

// File: rtl/ahr_decode.sv
module ahr_decode
  import ahr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              host_o,
  output logic              known_o,
  output reg_sel_e          sel_o,
  output logic [DEV_AW-1:0] dev_addr_o
);
  assign host_o     = addr_i[ADDR_W-1];
  assign known_o    = (addr_i[ADDR_W-2:5] == '0);
  assign sel_o      = reg_sel_e'(addr_i[4:2]);
  assign dev_addr_o = addr_i[DEV_AW-1:0];
endmodule

// File: rtl/ahr_timing_bank.sv
module ahr_timing_bank
  import ahr_pkg::*;
#(
  parameter int unsigned          N = N_TIM,
  parameter logic [N-1:0][DW-1:0] RST_VAL = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         we_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [N-1:0][DW-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[i] <= RST_VAL[i];
      else if (we_i[i]) q_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/ahr_irq_flag.sv
module ahr_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority so a concurrent event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/ata_host_regs.sv
module ata_host_regs
  import ahr_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned FEATURE_LEVEL = 3,
  parameter int unsigned REVISION      = 0,
  parameter int unsigned PIO_T1        = 6,
  parameter int unsigned PIO_T2        = 28,
  parameter int unsigned PIO_T4        = 2,
  parameter int unsigned PIO_TEOC      = 23,
  parameter int unsigned DMA_TM        = 4,
  parameter int unsigned DMA_TD        = 21,
  parameter int unsigned DMA_TEOC      = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              ack_o,
  output logic [31:0]       rdata_o,
  input  logic              irq_raise_i,
  output logic              irq_o,
  output logic              dev_rst_o,
  output logic              dev_req_o,
  output logic              dev_we_o,
  output logic [6:0]        dev_addr_o,
  output logic [31:0]       dev_wdata_o,
  input  logic              dev_ack_i,
  input  logic [31:0]       dev_rdata_i,
  input  logic              rx_load_i,
  input  logic [31:0]       rx_data_i,
  output logic [31:0]       tx_data_o
);
  localparam int unsigned LVL = (FEATURE_LEVEL >= 1 && FEATURE_LEVEL <= 3) ? FEATURE_LEVEL : 1;
  localparam logic [3:0]  LVL4 = 4'(LVL);
  localparam logic [3:0]  REV4 = 4'(REVISION);
  localparam int unsigned LAT = 2;
  localparam logic [DW-1:0] PIO_RST = pack_pio(PIO_T1, PIO_T2, PIO_T4, PIO_TEOC);
  localparam logic [DW-1:0] DMA_RST = pack_dma(DMA_TM, DMA_TD, DMA_TEOC);
  // bank order: compat PIO, fast0, fast1, dma0, dma1
  localparam logic [N_TIM-1:0][DW-1:0] TIM_RST = {DMA_RST, DMA_RST, PIO_RST, PIO_RST, PIO_RST};

  logic              host, known;
  reg_sel_e          sel;
  logic [DW-1:0]     ctrl_q, rxb_q, txb_q, rd_mux;
  logic [N_TIM-1:0]  tim_we;
  logic [N_TIM-1:0][DW-1:0] tim_q;
  logic              host_wr, en, local_req, stat_clr;
  logic [LAT-1:0]    pipe_vld;
  logic [DW-1:0]     pipe_dat [LAT];

  ahr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .host_o     (host),
    .known_o    (known),
    .sel_o      (sel),
    .dev_addr_o (dev_addr_o)
  );

  assign en      = ctrl_q[CTRL_EN_BIT];
  assign host_wr = req_i && we_i && host && known;

  for (genvar i = 0; i < N_TIM; i++) begin : g_twe
    assign tim_we[i] = host_wr && (sel == reg_sel_e'(int'(SEL_PIO) + i));
  end

  ahr_timing_bank #(.N(N_TIM), .RST_VAL(TIM_RST)) u_tim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tim_we),
    .wdata_i (wdata_i),
    .q_o     (tim_q)
  );

  assign stat_clr = host_wr && (sel == SEL_STAT) && !wdata_i[STAT_IRQ_BIT];

  ahr_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_raise_i),
    .clr_i  (stat_clr),
    .flag_o (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 32'h0000_0001;
      txb_q  <= '0;
      rxb_q  <= '0;
    end else begin
      if (host_wr && sel == SEL_CTRL) ctrl_q <= wdata_i;
      if (host_wr && sel == SEL_BUF)  txb_q  <= wdata_i;
      if (rx_load_i)                  rxb_q  <= rx_data_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (known) begin
      unique case (sel)
        SEL_CTRL:  rd_mux = ctrl_q;
        SEL_STAT:  rd_mux = {LVL4, REV4, 23'd0, irq_o};
        SEL_PIO:   rd_mux = tim_q[0];
        SEL_FAST0: rd_mux = (LVL > 1) ? tim_q[1] : '0;
        SEL_FAST1: rd_mux = (LVL > 1) ? tim_q[2] : '0;
        SEL_DMA0:  rd_mux = (LVL > 2) ? tim_q[3] : '0;
        SEL_DMA1:  rd_mux = (LVL > 2) ? tim_q[4] : '0;
        SEL_BUF:   rd_mux = (LVL > 2) ? rxb_q : '0;
        default:   rd_mux = '0;
      endcase
    end
  end

  // fixed-latency completion for host accesses and refused drive accesses
  assign local_req = req_i && (host || !en);

  for (genvar s = 0; s < LAT; s++) begin : g_pipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_vld[s] <= 1'b0;
        pipe_dat[s] <= '0;
      end else if (s == 0) begin
        pipe_vld[s] <= local_req;
        pipe_dat[s] <= (local_req && host && !we_i) ? rd_mux : '0;
      end else begin
        pipe_vld[s] <= pipe_vld[s-1];
        pipe_dat[s] <= pipe_dat[s-1];
      end
    end
  end

  assign dev_req_o   = req_i && !host && en;
  assign dev_we_o    = we_i;
  assign dev_wdata_o = wdata_i;
  assign dev_rst_o   = ctrl_q[CTRL_RST_BIT];
  assign tx_data_o   = txb_q;

  assign ack_o   = pipe_vld[LAT-1] || dev_ack_i;
  assign rdata_o = pipe_vld[LAT-1] ? pipe_dat[LAT-1] : (dev_ack_i ? dev_rdata_i : '0);
endmodule

// File: rtl/ahr_checker.sv
module ahr_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              ack_o,
  input logic              irq_raise_i,
  input logic              irq_o,
  input logic              dev_rst_o,
  input logic              dev_req_o,
  input logic              en_i
);
  logic host_a, stat_a, ctrl_a;
  assign host_a = addr_i[ADDR_W-1];
  assign stat_a = host_a && (addr_i[ADDR_W-2:2] == (ADDR_W-3)'(1));
  assign ctrl_a = host_a && (addr_i[ADDR_W-2:2] == '0);

  assert_host_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (host_a || !en_i) |-> ##2 ack_o);

  assert_irq_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_raise_i |=> irq_o);

  assert_irq_clear_by_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(req_i && we_i && stat_a && !wdata_i[0] && !irq_raise_i));

  assert_dev_rst_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && ctrl_a |=> dev_rst_o == $past(wdata_i[0]));

  assert_fwd_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o |-> en_i && req_i && !host_a);

  assert_no_fwd_disabled_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !host_a && !en_i |-> !dev_req_o);
endmodule

bind ata_host_regs ahr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .ack_o       (ack_o),
  .irq_raise_i (irq_raise_i),
  .irq_o       (irq_o),
  .dev_rst_o   (dev_rst_o),
  .dev_req_o   (dev_req_o),
  .en_i        (ctrl_q[7])
);

// File: tb/ata_host_regs_tb.sv
module ata_host_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  localparam int LVL [NI] = '{3, 1, 1};
  localparam logic [3:0] REV [NI] = '{4'h5, 4'hA, 4'h3};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0, irq_raise_i = 0, rx_load_i = 0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rx_data_i = '0;

  logic [NI-1:0] ack, irq, drst, dreq, dwe;
  logic [31:0]   rdata [NI];
  logic [31:0]   dwdata [NI];
  logic [31:0]   txd [NI];
  logic [6:0]    daddr [NI];
  logic          stub_ack;
  logic [31:0]   stub_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] ctrl_m, rx_m, tx_m;
  logic [31:0] tim_m [5];
  logic        irq_m;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign stub_ack   = dreq[0];
  assign stub_rdata = 32'hA500_0000 | {25'd0, daddr[0]};

  ata_host_regs #(.FEATURE_LEVEL(3), .REVISION(5)) dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ack_o(ack[0]), .rdata_o(rdata[0]), .irq_raise_i, .irq_o(irq[0]),
    .dev_rst_o(drst[0]), .dev_req_o(dreq[0]), .dev_we_o(dwe[0]),
    .dev_addr_o(daddr[0]), .dev_wdata_o(dwdata[0]),
    .dev_ack_i(stub_ack), .dev_rdata_i(stub_rdata),
    .rx_load_i, .rx_data_i, .tx_data_o(txd[0]));

  ata_host_regs #(.FEATURE_LEVEL(1), .REVISION(26)) dut_l1 (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ack_o(ack[1]), .rdata_o(rdata[1]), .irq_raise_i, .irq_o(irq[1]),
    .dev_rst_o(drst[1]), .dev_req_o(dreq[1]), .dev_we_o(dwe[1]),
    .dev_addr_o(daddr[1]), .dev_wdata_o(dwdata[1]),
    .dev_ack_i(1'b0), .dev_rdata_i(32'd0),
    .rx_load_i, .rx_data_i, .tx_data_o(txd[1]));

  ata_host_regs #(.FEATURE_LEVEL(7), .REVISION(3)) dut_lx (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ack_o(ack[2]), .rdata_o(rdata[2]), .irq_raise_i, .irq_o(irq[2]),
    .dev_rst_o(drst[2]), .dev_req_o(dreq[2]), .dev_we_o(dwe[2]),
    .dev_addr_o(daddr[2]), .dev_wdata_o(dwdata[2]),
    .dev_ack_i(1'b0), .dev_rdata_i(32'd0),
    .rx_load_i, .rx_data_i, .tx_data_o(txd[2]));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(int k, int idx);
    case (idx)
      0: return ctrl_m;
      1: return {4'(LVL[k]), REV[k], 23'd0, irq_m};
      2: return tim_m[0];
      3, 4: return (LVL[k] > 1) ? tim_m[idx-2] : 32'd0;
      5, 6: return (LVL[k] > 2) ? tim_m[idx-2] : 32'd0;
      7: return (LVL[k] > 2) ? rx_m : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  // pipelined access: ack due exactly two edges after the request cycle
  task automatic host_op(input logic w, input logic [7:0] a, input logic [31:0] d,
                         input logic raise, input string tag, output logic [31:0] r [NI]);
    @(negedge clk_i);
    req_i = 1; we_i = w; addr_i = a; wdata_i = d; irq_raise_i = raise;
    #1 chk({tag, " R12 no forward"}, 32'(dreq), 32'd0);
    @(negedge clk_i);
    req_i = 0; we_i = 0; irq_raise_i = 0;
    chk({tag, " R10 ack early"}, 32'(ack), 32'd0);
    @(negedge clk_i);
    chk({tag, " R10 ack due"}, 32'(ack), 32'h7);
    for (int k = 0; k < NI; k++) r[k] = rdata[k];
  endtask

  task automatic sweep(input string tag);
    logic [31:0] r [NI];
    for (int idx = 0; idx < 8; idx++) begin
      host_op(1'b0, 8'h80 | 8'(idx << 2), 32'd0, 1'b0, tag, r);
      for (int k = 0; k < NI; k++)
        chk($sformatf("%s R13 R4 R5 R2 inst%0d off%0d", tag, k, idx), r[k], exp_rd(k, idx));
    end
  endtask

  task automatic model_write(input int idx, input logic [31:0] d);
    case (idx)
      0: ctrl_m = d;
      1: if (!d[0]) irq_m = 1'b0;
      2, 3, 4, 5, 6: tim_m[idx-2] = d;
      7: tx_m = d;
      default: ;
    endcase
  endtask

  initial begin
    logic [31:0] r [NI];
    ctrl_m = 32'h1; rx_m = '0; tx_m = '0; irq_m = 0;
    for (int i = 0; i < 3; i++) tim_m[i] = 32'h1702_1C06;
    for (int i = 3; i < 5; i++) tim_m[i] = 32'h1500_1504;

    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 dev_rst after reset", 32'(drst), 32'h7);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 ack idle", 32'(ack), 32'h0);
    sweep("R1 R3 reset");

    // receive buffer load
    @(negedge clk_i); rx_load_i = 1; rx_data_i = 32'h5EED_1234;
    @(negedge clk_i); rx_load_i = 0; rx_m = 32'h5EED_1234;

    // write every writable offset, keep reset bit set and enable clear
    for (int idx = 0; idx < 8; idx++) begin
      logic [31:0] d;
      if (idx == 1) continue;
      d = (idx == 0) ? 32'h3C00_0041 : (32'hC0DE_0000 | 32'(idx * 32'h0101_0011));
      host_op(1'b1, 8'h80 | 8'(idx << 2), d, 1'b0, "R13 write", r);
      model_write(idx, d);
    end
    for (int k = 0; k < NI; k++) chk($sformatf("R5 tx inst%0d", k), txd[k], tx_m);
    sweep("R13 R4 R5 after write");

    // R6 unknown host addresses
    host_op(1'b1, 8'hA0, 32'hFFFF_FFFF, 1'b0, "R6", r);
    host_op(1'b1, 8'hE8, 32'h0, 1'b0, "R6", r);
    host_op(1'b0, 8'hA0, 32'd0, 1'b0, "R6", r);
    for (int k = 0; k < NI; k++) chk($sformatf("R6 unknown read inst%0d", k), r[k], 32'd0);
    sweep("R6 unchanged");

    // R7 interrupt raise
    @(negedge clk_i); irq_raise_i = 1;
    @(negedge clk_i); irq_raise_i = 0; irq_m = 1;
    chk("R7 irq set", 32'(irq), 32'h7);
    @(negedge clk_i); irq_raise_i = 1;
    @(negedge clk_i); irq_raise_i = 0;
    chk("R7 irq re-raise holds", 32'(irq), 32'h7);
    // R8 write of 1 and of upper bits leaves status alone
    host_op(1'b1, 8'h84, 32'hFFFF_FFFF, 1'b0, "R8", r);
    chk("R8 irq kept by bit0=1", 32'(irq), 32'h7);
    sweep("R8 status read-only");
    // R7 raise wins over same-cycle clear
    host_op(1'b1, 8'h84, 32'h0, 1'b1, "R7", r);
    chk("R7 raise beats clear", 32'(irq), 32'h7);
    // R8 clear
    host_op(1'b1, 8'h84, 32'hFFFF_FFFE, 1'b0, "R8", r);
    irq_m = 0;
    chk("R8 irq cleared", 32'(irq), 32'h0);
    host_op(1'b1, 8'h84, 32'h0, 1'b0, "R8", r);
    chk("R8 clear when clear", 32'(irq), 32'h0);
    sweep("R8 status");

    // R9 device reset follows bit 0
    host_op(1'b1, 8'h80, 32'h0000_0000, 1'b0, "R9", r);
    ctrl_m = 0;
    chk("R9 dev_rst low", 32'(drst), 32'h0);
    host_op(1'b1, 8'h80, 32'h0000_0001, 1'b0, "R9", r);
    ctrl_m = 1;
    chk("R9 dev_rst high", 32'(drst), 32'h7);

    // R12 disabled drive accesses
    for (int a = 0; a < 128; a += 37) begin
      host_op(1'b0, 8'(a), 32'd0, 1'b0, "R12 read", r);
      for (int k = 0; k < NI; k++) chk($sformatf("R12 zero data inst%0d a%0d", k, a), r[k], 32'd0);
    end
    host_op(1'b1, 8'h10, 32'h1234_5678, 1'b0, "R12 write", r);

    // R11 enable and forward
    host_op(1'b1, 8'h80, 32'h0000_0080, 1'b0, "R11 enable", r);
    ctrl_m = 32'h80;
    chk("R11 dev_rst released", 32'(drst[0]), 32'h0);
    for (int a = 3; a < 128; a += 29) begin
      @(negedge clk_i);
      req_i = 1; we_i = 0; addr_i = 8'(a); wdata_i = '0;
      #1;
      chk($sformatf("R11 dev_req a%0d", a), 32'(dreq[0]), 32'h1);
      chk($sformatf("R11 dev_addr a%0d", a), 32'(daddr[0]), 32'(a));
      chk($sformatf("R11 ack same cycle a%0d", a), 32'(ack[0]), 32'h1);
      chk($sformatf("R11 rdata a%0d", a), rdata[0], 32'hA500_0000 | 32'(a));
      @(negedge clk_i); req_i = 0;
      @(negedge clk_i);
      chk($sformatf("R11 no late ack a%0d", a), 32'(ack[0]), 32'h0);
    end
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 8'h1F; wdata_i = 32'hDEAD_BEEF;
    #1;
    chk("R11 dev_we", 32'(dwe[0]), 32'h1);
    chk("R11 dev_wdata", dwdata[0], 32'hDEAD_BEEF);
    chk("R11 dev_addr write", 32'(daddr[0]), 32'h1F);
    @(negedge clk_i); req_i = 0; we_i = 0;
    sweep("R13 final");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule